// File: doc/BRIEF.md
# Lock-Step Shared Register File Write Resolver

This block sits in front of a small register file that several processor ports share. All ports run on one clock and act in lock-step. In each cycle a port may read one location, write one location, or stay idle. The block decides in a single cycle which writes land and with what value. It also raises per-address conflict flags according to an access discipline chosen at run time.

The discipline ranges from fully exclusive access to fully concurrent access. In exclusive access, colliding reads or writes are errors. Under concurrent writes there are three ways to settle a collision:
- the colliders must agree on the value;
- the lowest-numbered port wins;
- a rotating pointer names the winner.

Read data always shows the contents from before the writes of the same cycle. The register file is part of the block. There is no arbitration that spans several cycles.

Top module: `pram_access_resolver`

## Requirements
- R1: While `rst_n` is low, every location holds zero and the rotating pointer is 0. After reset is released, the pointer advances by one, modulo `NPORT`, on every clock edge.
- R2: `mode_i` selects the discipline. The codes are: 0 exclusive read and write; 1 shared read with exclusive write; 2 shared write where colliders must agree; 3 shared write where the lowest port wins; 4 shared write where the rotating pointer picks the winner. Codes 5 to 7 behave as code 0.
- R3: `rdata_o` slice p (bits p*DW up to p*DW+DW-1) returns the stored content at that port's address from before any write of the same cycle. A write becomes visible from the next cycle on.
- R4: A port that raises both `rd_req_i` and `wr_req_i` counts only as a writer. Its read is not counted toward read conflicts.
- R5: In codes 0 and 5 to 7, two or more reading ports on one address set `rd_conf_o[address]` for that cycle. The read data is still returned.
- R6: In codes 1 to 4, `rd_conf_o` stays all zero.
- R7: In codes 0, 1 and 5 to 7, two or more writers on one address set `wr_conf_o[address]`, and that location keeps its old value.
- R8: A lone writer on an address commits its data in every mode, and no flag is raised.
- R9: In code 2, colliding writers that supply equal data commit that data without a flag. Colliding writers that supply unequal data set `wr_conf_o[address]` and leave the location unchanged.
- R10: In code 3, the lowest-numbered colliding writer commits, and no flag is raised.
- R11: In code 4, the winner is the first writing port found when scanning upward from the pointer value and wrapping past `NPORT-1`. No flag is raised.
- R12: Addresses are resolved independently. Writes to distinct addresses in the same cycle all commit, and each flag bit reflects only its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| mode_i | input | 3 | Access discipline code |
| rd_req_i | input | NPORT | Read request, one bit per port |
| wr_req_i | input | NPORT | Write request, one bit per port |
| addr_i | input | NPORT*AW | Address per port, port p in bits p*AW upward |
| wdata_i | input | NPORT*DW | Write data per port, port p in bits p*DW upward |
| rdata_o | output | NPORT*DW | Read data per port, contents before this cycle's writes |
| rd_conf_o | output | DEPTH | Read conflict, one bit per address, current cycle |
| wr_conf_o | output | DEPTH | Write conflict, one bit per address, current cycle |

## Verification
The hardest case to reach from the ports is the rotating-winner mode. The pointer is never visible, so the expected winner depends on how many clock edges have passed since reset. The bench keeps its own edge count from reset release. It interleaves write collisions between two non-adjacent ports with two-cycle readbacks, so that over successive collisions the pointer sits at each of its positions and the wrap past the last port is exercised. Collisions whose data disagree, both under the agreeing-writers rule and in exclusive mode, are checked by reading the location back afterwards. This shows that the old value survived.

// File: rtl/pram_res_pkg.sv
package pram_res_pkg;

  typedef enum logic [2:0] {
    ACC_EXCL_BOTH = 3'd0,
    ACC_SHARED_RD = 3'd1,
    ACC_CW_SAME   = 3'd2,
    ACC_CW_LOWEST = 3'd3,
    ACC_CW_ROTATE = 3'd4
  } acc_mode_e;

  function automatic logic mode_excl_read(input logic [2:0] m);
    return !(m == ACC_SHARED_RD || m == ACC_CW_SAME ||
             m == ACC_CW_LOWEST || m == ACC_CW_ROTATE);
  endfunction

endpackage

// File: rtl/pram_rot_ptr.sv
module pram_rot_ptr #(
  parameter int NPORT = 4,
  parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] ptr_o
);

  localparam logic [PW-1:0] LAST = PW'(NPORT - 1);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;

  always_comb begin
    if (ptr_q == LAST) ptr_d = '0;
    else               ptr_d = ptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/pram_addr_slot.sv
module pram_addr_slot
  import pram_res_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int PW    = 2,
  parameter int SLOT  = 0
) (
  input  logic [2:0]          mode_i,
  input  logic [NPORT-1:0]    rd_req_i,
  input  logic [NPORT-1:0]    wr_req_i,
  input  logic [NPORT*AW-1:0] addr_i,
  input  logic [NPORT*DW-1:0] wdata_i,
  input  logic [PW-1:0]       ptr_i,
  output logic                rd_conf_o,
  output logic                wr_conf_o,
  output logic                we_o,
  output logic [DW-1:0]       wd_o
);

  localparam int            CW        = $clog2(NPORT + 1);
  localparam logic [AW-1:0] SLOT_ADDR = AW'(SLOT);

  logic [NPORT-1:0] rd_hit, wr_hit;
  logic [CW-1:0]    rd_cnt, wr_cnt;
  logic [PW-1:0]    low_idx, rot_idx;
  logic             low_found, rot_found;
  logic [DW-1:0]    low_data, rot_data;
  logic             same_val;
  logic             multi_wr;

  // address match per port; a writing port never counts as a reader
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      wr_hit[p] = wr_req_i[p] && (addr_i[p*AW +: AW] == SLOT_ADDR);
      rd_hit[p] = rd_req_i[p] && !wr_req_i[p] && (addr_i[p*AW +: AW] == SLOT_ADDR);
    end
  end

  always_comb begin
    rd_cnt = '0;
    wr_cnt = '0;
    for (int p = 0; p < NPORT; p++) begin
      rd_cnt = rd_cnt + CW'(rd_hit[p]);
      wr_cnt = wr_cnt + CW'(wr_hit[p]);
    end
  end

  // lowest-index writer
  always_comb begin
    low_found = 1'b0;
    low_idx   = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (wr_hit[p] && !low_found) begin
        low_found = 1'b1;
        low_idx   = PW'(p);
      end
    end
  end

  // first writer scanning upward from the rotating pointer
  always_comb begin
    int j;
    rot_found = 1'b0;
    rot_idx   = '0;
    for (int k = 0; k < NPORT; k++) begin
      j = int'(ptr_i) + k;
      if (j >= NPORT) j = j - NPORT;
      if (wr_hit[j] && !rot_found) begin
        rot_found = 1'b1;
        rot_idx   = PW'(j);
      end
    end
  end

  always_comb begin
    low_data = '0;
    rot_data = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (low_idx == PW'(p)) low_data = wdata_i[p*DW +: DW];
      if (rot_idx == PW'(p)) rot_data = wdata_i[p*DW +: DW];
    end
  end

  always_comb begin
    same_val = 1'b1;
    for (int p = 0; p < NPORT; p++) begin
      if (wr_hit[p] && (wdata_i[p*DW +: DW] != low_data)) same_val = 1'b0;
    end
  end

  assign multi_wr  = (wr_cnt > CW'(1));
  assign rd_conf_o = mode_excl_read(mode_i) && (rd_cnt > CW'(1));

  always_comb begin
    we_o      = 1'b0;
    wd_o      = low_data;
    wr_conf_o = 1'b0;
    case (mode_i)
      ACC_CW_SAME: begin
        wr_conf_o = multi_wr && !same_val;
        we_o      = low_found && !wr_conf_o;
      end
      ACC_CW_LOWEST: begin
        we_o = low_found;
      end
      ACC_CW_ROTATE: begin
        we_o = rot_found;
        wd_o = rot_data;
      end
      default: begin
        wr_conf_o = multi_wr;
        we_o      = low_found && !multi_wr;
      end
    endcase
  end

endmodule

// File: rtl/pram_regfile.sv
module pram_regfile #(
  parameter int NPORT = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DEPTH-1:0]    we_i,
  input  logic [DEPTH*DW-1:0] wd_i,
  input  logic [NPORT*AW-1:0] addr_i,
  output logic [NPORT*DW-1:0] rdata_o,
  output logic [DEPTH*DW-1:0] mem_flat_o
);

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    logic [DW-1:0] ent_d;

    always_comb begin
      ent_d = mem_q[a];
      if (we_i[a]) ent_d = wd_i[a*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[a] <= '0;
      else if (we_i[a]) mem_q[a] <= ent_d;
    end

    assign mem_flat_o[a*DW +: DW] = mem_q[a];
  end

  // reads see the registered contents, i.e. the state before this cycle's writes
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rdata_o[p*DW +: DW] = '0;
      for (int a = 0; a < DEPTH; a++) begin
        if (addr_i[p*AW +: AW] == AW'(a)) rdata_o[p*DW +: DW] = mem_q[a];
      end
    end
  end

endmodule

// File: rtl/pram_access_resolver.sv
module pram_access_resolver #(
  parameter int NPORT = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode_i,
  input  logic [NPORT-1:0]    rd_req_i,
  input  logic [NPORT-1:0]    wr_req_i,
  input  logic [NPORT*AW-1:0] addr_i,
  input  logic [NPORT*DW-1:0] wdata_i,
  output logic [NPORT*DW-1:0] rdata_o,
  output logic [DEPTH-1:0]    rd_conf_o,
  output logic [DEPTH-1:0]    wr_conf_o
);

  logic [PW-1:0]       rot_ptr;
  logic [DEPTH-1:0]    slot_we;
  logic [DEPTH*DW-1:0] slot_wd;
  logic [DEPTH*DW-1:0] mem_flat;

  pram_rot_ptr #(.NPORT(NPORT), .PW(PW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .ptr_o (rot_ptr)
  );

  for (genvar a = 0; a < DEPTH; a++) begin : g_slot
    pram_addr_slot #(
      .NPORT(NPORT), .AW(AW), .DW(DW), .PW(PW), .SLOT(a)
    ) u_slot (
      .mode_i    (mode_i),
      .rd_req_i  (rd_req_i),
      .wr_req_i  (wr_req_i),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .ptr_i     (rot_ptr),
      .rd_conf_o (rd_conf_o[a]),
      .wr_conf_o (wr_conf_o[a]),
      .we_o      (slot_we[a]),
      .wd_o      (slot_wd[a*DW +: DW])
    );
  end

  pram_regfile #(.NPORT(NPORT), .DEPTH(DEPTH), .DW(DW), .AW(AW)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (slot_we),
    .wd_i       (slot_wd),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .mem_flat_o (mem_flat)
  );

endmodule

// File: rtl/pram_resolver_chk.sv
module pram_resolver_chk #(
  parameter int NPORT = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int PW    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          mode_i,
  input logic [DEPTH-1:0]    rd_conf_o,
  input logic [DEPTH-1:0]    wr_conf_o,
  input logic [DEPTH*DW-1:0] mem_flat,
  input logic [PW-1:0]       ptr
);

  // R6
  shared_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i >= 3'd1 && mode_i <= 3'd4) |-> (rd_conf_o == '0));

  // R10
  lossless_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd3 || mode_i == 3'd4) |-> (wr_conf_o == '0));

  // R1
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(NPORT - 1));

  // R11
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ptr == (($past(ptr) == PW'(NPORT - 1)) ? '0 : $past(ptr) + PW'(1))));

  for (genvar a = 0; a < DEPTH; a++) begin : g_hold
    // R7
    conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_conf_o[a] |=> (mem_flat[a*DW +: DW] == $past(mem_flat[a*DW +: DW])));
  end

endmodule

bind pram_access_resolver pram_resolver_chk #(
  .NPORT(NPORT), .DEPTH(DEPTH), .DW(DW), .PW(PW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .rd_conf_o (rd_conf_o),
  .wr_conf_o (wr_conf_o),
  .mem_flat  (mem_flat),
  .ptr       (rot_ptr)
);

// File: tb/test_pram_access_resolver.sv
module test_pram_access_resolver;

  localparam int NP = 4;
  localparam int DP = 8;
  localparam int W  = 8;
  localparam int A  = 3;

  typedef struct packed {
    logic [2:0]  mode;
    logic [3:0]  rd;
    logic [3:0]  wr;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [7:0]  rc;
    logic [7:0]  wc;
    logic        e0;
    logic [2:0]  a0;
    logic [7:0]  d0;
    logic        e1;
    logic [2:0]  a1;
    logic [7:0]  d1;
  } vec_t;

  localparam int NV = 11;
  // addr and wd are {port3, port2, port1, port0}
  localparam vec_t TBL [NV] = '{
    '{3'd0, 4'b0100, 4'b0011, {3'd0,3'd1,3'd2,3'd1}, {8'h00,8'h00,8'h22,8'h11}, 8'h00, 8'h00, 1'b1,3'd1,8'h11, 1'b1,3'd2,8'h22},
    '{3'd0, 4'b0011, 4'b0100, {3'd0,3'd3,3'd1,3'd1}, {8'h00,8'h33,8'h00,8'h00}, 8'h02, 8'h00, 1'b1,3'd3,8'h33, 1'b0,3'd0,8'h00},
    '{3'd0, 4'b1100, 4'b0011, {3'd5,3'd2,3'd2,3'd2}, {8'h00,8'h00,8'h55,8'h44}, 8'h00, 8'h04, 1'b0,3'd0,8'h00, 1'b0,3'd0,8'h00},
    '{3'd1, 4'b0111, 4'b1000, {3'd4,3'd1,3'd1,3'd1}, {8'h66,8'h00,8'h00,8'h00}, 8'h00, 8'h00, 1'b1,3'd4,8'h66, 1'b0,3'd0,8'h00},
    '{3'd1, 4'b0110, 4'b1001, {3'd1,3'd3,3'd3,3'd1}, {8'h88,8'h00,8'h00,8'h77}, 8'h00, 8'h02, 1'b0,3'd0,8'h00, 1'b0,3'd0,8'h00},
    '{3'd2, 4'b0000, 4'b1111, {3'd6,3'd5,3'd5,3'd5}, {8'h0A,8'h99,8'h99,8'h99}, 8'h00, 8'h00, 1'b1,3'd5,8'h99, 1'b1,3'd6,8'h0A},
    '{3'd2, 4'b1001, 4'b0110, {3'd5,3'd5,3'd5,3'd5}, {8'h00,8'h02,8'h01,8'h00}, 8'h00, 8'h20, 1'b0,3'd0,8'h00, 1'b0,3'd0,8'h00},
    '{3'd3, 4'b0001, 4'b1110, {3'd7,3'd7,3'd7,3'd7}, {8'hB3,8'hB2,8'hB1,8'h00}, 8'h00, 8'h00, 1'b1,3'd7,8'hB1, 1'b0,3'd0,8'h00},
    '{3'd3, 4'b0000, 4'b1001, {3'd0,3'd6,3'd6,3'd0}, {8'hC3,8'h00,8'h00,8'hC0}, 8'h00, 8'h00, 1'b1,3'd0,8'hC0, 1'b0,3'd0,8'h00},
    '{3'd6, 4'b0011, 4'b1100, {3'd1,3'd1,3'd2,3'd2}, {8'hD2,8'hD1,8'h00,8'h00}, 8'h04, 8'h02, 1'b0,3'd0,8'h00, 1'b0,3'd0,8'h00},
    '{3'd0, 4'b0011, 4'b0001, {3'd0,3'd0,3'd3,3'd3}, {8'h00,8'h00,8'h00,8'hE0}, 8'h00, 8'h00, 1'b1,3'd3,8'hE0, 1'b0,3'd0,8'h00}
  };

  logic            clk;
  logic            rst_n;
  logic [2:0]      mode_i;
  logic [NP-1:0]   rd_req_i;
  logic [NP-1:0]   wr_req_i;
  logic [NP*A-1:0] addr_i;
  logic [NP*W-1:0] wdata_i;
  logic [NP*W-1:0] rdata_o;
  logic [DP-1:0]   rd_conf_o;
  logic [DP-1:0]   wr_conf_o;

  int          checks;
  int          fails;
  int          cyc;
  logic [7:0]  shadow [DP];

  pram_access_resolver #(.NPORT(NP), .DEPTH(DP), .DW(W)) i_pram_access_resolver (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .rd_req_i  (rd_req_i),
    .wr_req_i  (wr_req_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .rd_conf_o (rd_conf_o),
    .wr_conf_o (wr_conf_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // edge count since reset release, mirrors the rotating pointer position
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rd_req_i = '0;
    wr_req_i = '0;
    addr_i   = '0;
    wdata_i  = '0;
    mode_i   = 3'd1;
  endtask

  task automatic readback(input string tag);
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      mode_i   = 3'd1;
      rd_req_i = '1;
      wr_req_i = '0;
      for (int p = 0; p < NP; p++) addr_i[p*A +: A] = 3'(h*4 + p);
      #2;
      for (int p = 0; p < NP; p++) check(tag, 64'(rdata_o[p*W +: W]), 64'(shadow[h*4 + p]));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    check("R1 conflict flags in reset", 64'({rd_conf_o, wr_conf_o}), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < DP; a++) shadow[a] = 8'h00;
  endtask

  initial begin
    #(100000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks   = 0;
    fails    = 0;
    rst_n    = 1'b0;
    mode_i   = 3'd0;
    rd_req_i = '0;
    wr_req_i = '0;
    addr_i   = '0;
    wdata_i  = '0;
    do_reset();
    readback("R1 reset contents");

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode_i   = TBL[v].mode;
      rd_req_i = TBL[v].rd;
      wr_req_i = TBL[v].wr;
      addr_i   = TBL[v].addr;
      wdata_i  = TBL[v].wd;
      #2;
      check($sformatf("R5 R6 R2 row %0d read flags", v), 64'(rd_conf_o), 64'(TBL[v].rc));
      check($sformatf("R7 R9 R12 R4 row %0d write flags", v), 64'(wr_conf_o), 64'(TBL[v].wc));
      for (int p = 0; p < NP; p++)
        check($sformatf("R3 row %0d port %0d pre-write data", v, p),
              64'(rdata_o[p*W +: W]), 64'(shadow[TBL[v].addr[p*A +: A]]));
      if (TBL[v].e0) shadow[TBL[v].a0] = TBL[v].d0;
      if (TBL[v].e1) shadow[TBL[v].a1] = TBL[v].d1;
      readback($sformatf("R8 R10 R12 R4 R7 R9 row %0d contents", v));
    end

    // rotating winner, all four ports collide
    @(negedge clk);
    mode_i   = 3'd4;
    rd_req_i = '0;
    wr_req_i = 4'b1111;
    addr_i   = {3'd6, 3'd6, 3'd6, 3'd6};
    wdata_i  = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
    #2;
    check("R11 all-port collision flag", 64'(wr_conf_o), 64'(0));
    shadow[6] = 8'hA0 + 8'(cyc % NP);
    readback("R11 all-port winner");

    // rotating winner, ports 1 and 3 collide, pointer visits every position
    for (int it = 0; it < 4; it++) begin
      int k;
      int win;
      @(negedge clk);
      mode_i   = 3'd4;
      rd_req_i = '0;
      wr_req_i = 4'b1010;
      addr_i   = {3'd7, 3'd0, 3'd7, 3'd0};
      wdata_i  = {8'h90 + 8'(it), 8'h00, 8'h70 + 8'(it), 8'h00};
      #2;
      check("R11 two-port collision flag", 64'(wr_conf_o), 64'(0));
      k   = cyc % NP;
      win = (k == 0 || k == 1) ? 1 : 3;
      shadow[7] = (win == 1) ? 8'h70 + 8'(it) : 8'h90 + 8'(it);
      readback($sformatf("R11 winner from pointer %0d", k));
    end

    // reset again mid-run
    do_reset();
    idle();
    readback("R1 contents after second reset");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule